// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block gives software control of up to 144 general-purpose pins through a 32-bit register bus. The pins are split into register sets of 32. Pin n belongs to set n/32 and uses bit n mod 32 of every register in that set. For each pin, software chooses a direction and drives an output level. It can also read back the real pin level and arm edge detection on rising edges, falling edges or both.

A detected edge latches a sticky status bit. Each set is split into two groups of 16 pins, and each group has its own interrupt line. The line rises when any status bit of that group is set and software has enabled the group in the global group-enable register. The handler reads the status word of the set and clears the bits it has serviced by writing ones to them.

The register bus never stalls. A write takes effect on the clock edge that samples it. Read data appears on `bus_rdata` one cycle after the edge that samples `bus_rd`, and it holds until the next read. The pin and interrupt vectors are plain level signals and have no handshake.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, every direction bit reads 1, the output, edge-enable, status and group-enable registers read 0, `pin_oe` and `pin_out` are all low and every `irq` line is low.
- R2: The group-enable register is at byte address 0x08. Set k starts at 0x10 + 0x28*k. Within a set the word offsets are: 0x00 direction, 0x04 output data (read/write), 0x08 set-data, 0x0C clear-data, 0x10 input level, 0x14 rise-set, 0x18 rise-clear, 0x1C fall-set, 0x20 fall-clear, 0x24 status. Any other address reads 0, and read data appears one cycle after the read is sampled.
- R3: A direction bit of 1 makes the pin an input with `pin_oe` low. A 0 makes it an output with `pin_oe` high.
- R4: A write to the set-data port drives the masked output bits high and leaves bits written as 0 unchanged. A write to the output data register replaces the whole word.
- R5: A write to the clear-data port drives the masked output bits low and leaves the other bits unchanged. Reads of the set-data and clear-data ports return the output register.
- R6: The input level register returns the pin level through a two-flop synchronizer, also for pins configured as outputs. A read sampled one cycle after a pin change still returns the old level. A read sampled two cycles after returns the new level.
- R7: The rising and falling enables are changed per pin through their own set and clear ports, and both may be on at once. Reads of the rise-set and rise-clear ports return the rising mask, and reads of the fall-set and fall-clear ports return the falling mask.
- R8: An enabled edge on a pin sets that pin's status bit. An edge of a kind that is not enabled leaves the status unchanged.
- R9: Writing ones to the status register clears those bits. Bits written as 0 keep their value.
- R10: If an edge is latched in the same cycle that the write-one clears the same status bit, the bit stays set.
- R11: Interrupt line g is high exactly when one of the status bits of pins 16g to 16g+15 is set and bit g of the group-enable register is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| pin_in | input | NUM_PINS | Pin levels from the pads |
| pin_out | output | NUM_PINS | Output levels to the pads |
| pin_oe | output | NUM_PINS | Output driver enables |
| irq | output | NUM_GROUPS | Per-group interrupt lines |

## Verification
Edge detection is exercised with rising-only, falling-only and dual-edge enables on the same pin. This separates the two edge masks from each other and shows that disabling an edge suppresses it. Pins are placed on both sides of a 16-pin boundary, on a 32-pin set boundary and on the last pin. A wrong set base or a wrong group split therefore lights the wrong interrupt line. Partial write-one clears are applied, and one clear is timed to coincide with an edge, which separates clear priority from edge priority. Input reads taken one and two cycles after a pin change pin down the synchronizer depth.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int SET_PINS   = 32;
  localparam int GRP_PINS   = 16;
  localparam int SET_STRIDE = 40;
  localparam int SET_BASE0  = 16;
  localparam int GEN_ADDR   = 8;

  typedef enum logic [3:0] {
    RIDX_DIR   = 4'd0,
    RIDX_OUT   = 4'd1,
    RIDX_SET   = 4'd2,
    RIDX_CLR   = 4'd3,
    RIDX_IN    = 4'd4,
    RIDX_RSET  = 4'd5,
    RIDX_RCLR  = 4'd6,
    RIDX_FSET  = 4'd7,
    RIDX_FCLR  = 4'd8,
    RIDX_STAT  = 4'd9
  } gpio_reg_e;

  localparam int SET_WORDS = 10;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_prev
);

  logic [W-1:0] meta_q;
  logic [W-1:0] lvl_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl      = lvl_q;
  assign lvl_prev = prev_q;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  gpio_reg_e        reg_idx,
  input  logic [31:0]      wdata,
  input  logic [31:0]      lvl,
  input  logic [31:0]      lvl_prev,
  output logic [31:0]      rdata,
  output logic [31:0]      dir_q,
  output logic [31:0]      out_q,
  output logic [31:0]      stat_q
);

  logic [31:0] rise_q;
  logic [31:0] fall_q;
  logic [31:0] edge_hit;
  logic [31:0] w1c_mask;

  always_comb begin
    edge_hit = (lvl & ~lvl_prev & rise_q) | (~lvl & lvl_prev & fall_q);
    w1c_mask = (wr_en && reg_idx == RIDX_STAT) ? wdata : 32'h0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= '1;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
    end else begin
      stat_q <= (stat_q & ~w1c_mask) | edge_hit;
      if (wr_en) begin
        case (reg_idx)
          RIDX_DIR:  dir_q  <= wdata;
          RIDX_OUT:  out_q  <= wdata;
          RIDX_SET:  out_q  <= out_q | wdata;
          RIDX_CLR:  out_q  <= out_q & ~wdata;
          RIDX_RSET: rise_q <= rise_q | wdata;
          RIDX_RCLR: rise_q <= rise_q & ~wdata;
          RIDX_FSET: fall_q <= fall_q | wdata;
          RIDX_FCLR: fall_q <= fall_q & ~wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_idx)
      RIDX_DIR:                     rdata = dir_q;
      RIDX_OUT, RIDX_SET, RIDX_CLR: rdata = out_q;
      RIDX_IN:                      rdata = lvl;
      RIDX_RSET, RIDX_RCLR:         rdata = rise_q;
      RIDX_FSET, RIDX_FCLR:         rdata = fall_q;
      RIDX_STAT:                    rdata = stat_q;
      default:                      rdata = 32'h0;
    endcase
  end

  // R4: set-data port raises every masked bit
  a_r4_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == RIDX_SET) |=> ((out_q & $past(wdata)) == $past(wdata)));

  // R5: clear-data port lowers every masked bit
  a_r5_clr_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == RIDX_CLR) |=> ((out_q & $past(wdata)) == 32'h0));

  // R9: without a status write no status bit drops
  a_r9_sticky_status: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && reg_idx == RIDX_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R8: a status bit rises only on an enabled edge
  a_r8_status_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(edge_hit)) == 32'h0));

  // R10: an edge coinciding with its clear leaves the bit set
  a_r10_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != 32'h0) |=> ((stat_q & $past(edge_hit)) == $past(edge_hit)));

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge
  import gpio_pkg::*;
#(
  parameter int PAD_W      = 160,
  parameter int NUM_GROUPS = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PAD_W-1:0]      stat_all,
  input  logic [NUM_GROUPS-1:0] grp_en,
  output logic [NUM_GROUPS-1:0] irq
);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign irq[g] = grp_en[g] & (|stat_all[g*GRP_PINS +: GRP_PINS]);

    // R11: a line is only high while its group is enabled
    a_r11_line_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |-> grp_en[g]);
  end

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PINS   = 144,
  parameter int ADDR_W     = 8,
  parameter int NUM_SETS   = (NUM_PINS + SET_PINS - 1) / SET_PINS,
  parameter int NUM_GROUPS = (NUM_PINS + GRP_PINS - 1) / GRP_PINS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_PINS-1:0]   pin_in,
  output logic [NUM_PINS-1:0]   pin_out,
  output logic [NUM_PINS-1:0]   pin_oe,
  output logic [NUM_GROUPS-1:0] irq
);

  localparam int PAD_W = NUM_SETS * SET_PINS;

  logic [31:0]           addr32;
  logic [PAD_W-1:0]      pin_pad;
  logic [PAD_W-1:0]      lvl_all;
  logic [PAD_W-1:0]      prev_all;
  logic [PAD_W-1:0]      dir_all;
  logic [PAD_W-1:0]      out_all;
  logic [PAD_W-1:0]      stat_all;
  logic [NUM_SETS-1:0]   set_hit;
  logic [31:0]           set_rd   [NUM_SETS];
  logic [NUM_GROUPS-1:0] grp_en_q;
  logic                  gen_hit;
  logic [31:0]           rd_mux;

  assign addr32  = 32'(bus_addr);
  assign gen_hit = (addr32 == 32'(GEN_ADDR));

  always_comb begin
    pin_pad = '0;
    pin_pad[NUM_PINS-1:0] = pin_in;
  end

  gpio_in_sync #(.W(PAD_W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw      (pin_pad),
    .lvl      (lvl_all),
    .lvl_prev (prev_all)
  );

  for (genvar k = 0; k < NUM_SETS; k++) begin : g_set
    localparam int BASE = SET_BASE0 + SET_STRIDE * k;
    logic [31:0] rel;
    logic [3:0]  idx;
    logic [31:0] bank_rd;

    assign rel        = addr32 - 32'(BASE);
    assign idx        = rel[5:2];
    assign set_hit[k] = (addr32 >= 32'(BASE)) &&
                        (addr32 < 32'(BASE + 4 * SET_WORDS)) &&
                        (addr32[1:0] == 2'b00);

    gpio_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr && set_hit[k]),
      .reg_idx  (gpio_reg_e'(idx)),
      .wdata    (bus_wdata),
      .lvl      (lvl_all[k*SET_PINS +: SET_PINS]),
      .lvl_prev (prev_all[k*SET_PINS +: SET_PINS]),
      .rdata    (bank_rd),
      .dir_q    (dir_all[k*SET_PINS +: SET_PINS]),
      .out_q    (out_all[k*SET_PINS +: SET_PINS]),
      .stat_q   (stat_all[k*SET_PINS +: SET_PINS])
    );

    assign set_rd[k] = set_hit[k] ? bank_rd : 32'h0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_en_q <= '0;
    end else if (bus_wr && gen_hit) begin
      grp_en_q <= bus_wdata[NUM_GROUPS-1:0];
    end
  end

  always_comb begin
    rd_mux = 32'h0;
    if (gen_hit) rd_mux[NUM_GROUPS-1:0] = grp_en_q;
    for (int k = 0; k < NUM_SETS; k++) rd_mux = rd_mux | set_rd[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= 32'h0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
    end
  end

  assign pin_out = out_all[NUM_PINS-1:0];
  assign pin_oe  = ~dir_all[NUM_PINS-1:0];

  gpio_irq_merge #(.PAD_W(PAD_W), .NUM_GROUPS(NUM_GROUPS)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .stat_all (stat_all),
    .grp_en   (grp_en_q),
    .irq      (irq)
  );

  // R2: at most one register set claims an address
  a_r2_one_set_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_hit));

  // R2: read data only changes after a sampled read
  a_r2_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/tb_gpio_ctrl.sv
module tb_gpio_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 144;
  localparam int NG = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;
  logic [NG-1:0] irq;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  function automatic logic [7:0] ra(int set, int off);
    return 8'(16 + 40 * set + off);
  endfunction

  localparam int O_DIR = 0, O_OUT = 4, O_SET = 8, O_CLR = 12, O_IN = 16,
                 O_RS = 20, O_RC = 24, O_FS = 28, O_FC = 32, O_ST = 36;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 oe", 32'(pin_oe[31:0] | pin_oe[143:112]), 32'h0);
    chk("R1 out", 32'(pin_out[31:0]), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    rd(ra(0, O_DIR), d); chk("R1 dir", d, 32'hFFFF_FFFF);
    rd(ra(4, O_ST), d);  chk("R1 status", d, 32'h0);
    rd(8'h08, d);        chk("R1 group enable", d, 32'h0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    rd(8'h0C, d); chk("R2 unmapped 0x0C", d, 32'h0);
    rd(8'hD8, d); chk("R2 unmapped 0xD8", d, 32'h0);
    wr(ra(3, O_OUT), 32'h1234_5678);
    rd(ra(3, O_OUT), d); chk("R2 set3 out", d, 32'h1234_5678);
    rd(ra(2, O_OUT), d); chk("R2 set2 untouched", d, 32'h0);
    chk("R2 pin_out set3", pin_out[127:96], 32'h1234_5678);
    wr(ra(3, O_OUT), 32'h0);
  endtask

  task automatic t_dir();
    logic [31:0] d;
    wr(ra(1, O_DIR), ~32'h0000_00F0);
    chk("R3 oe set1", pin_oe[63:32], 32'h0000_00F0);
    chk("R3 oe set0", pin_oe[31:0], 32'h0);
    wr(ra(4, O_DIR), ~32'h1);
    chk("R3 oe pin128", 32'(pin_oe[128]), 32'h1);
    rd(ra(1, O_DIR), d); chk("R3 dir readback", d, ~32'h0000_00F0);
  endtask

  task automatic t_data();
    logic [31:0] d;
    wr(ra(0, O_SET), 32'h0000_0011);
    chk("R4 set", pin_out[31:0], 32'h0000_0011);
    wr(ra(0, O_SET), 32'h0000_0100);
    chk("R4 set keeps others", pin_out[31:0], 32'h0000_0111);
    wr(ra(0, O_CLR), 32'h0000_0001);
    chk("R5 clear", pin_out[31:0], 32'h0000_0110);
    rd(ra(0, O_CLR), d); chk("R5 clear-port read", d, 32'h0000_0110);
    wr(ra(0, O_OUT), 32'hA5A5_A5A5);
    rd(ra(0, O_SET), d); chk("R4 direct write", d, 32'hA5A5_A5A5);
    wr(ra(0, O_OUT), 32'h0);
  endtask

  task automatic t_sync();
    logic [31:0] d;
    // pin 33 is configured as an output here (set1 dir bit1 = 0 above? no: bit4..7)
    wr(ra(1, O_DIR), ~32'h0000_00F2);
    pin_in[33] = 1'b1;
    rd(ra(1, O_IN), d); chk("R6 one cycle old", d & 32'h2, 32'h0);
    rd(ra(1, O_IN), d); chk("R6 new level on output pin", d & 32'h2, 32'h2);
  endtask

  task automatic t_edges();
    logic [31:0] d;
    wr(8'h08, 32'h1FF);
    wr(ra(0, O_RS), 32'h20);
    pin_in[5] = 1'b1; settle();
    rd(ra(0, O_ST), d); chk("R8 rise latched", d, 32'h20);
    chk("R11 irq0 up, irq1 down", 32'(irq[1:0]), 32'h1);
    wr(ra(0, O_ST), 32'h20);
    rd(ra(0, O_ST), d); chk("R9 cleared", d, 32'h0);
    chk("R11 irq0 down", 32'(irq[0]), 32'h0);
    pin_in[5] = 1'b0; settle();
    rd(ra(0, O_ST), d); chk("R8 fall ignored", d, 32'h0);
    rd(ra(0, O_RC), d); chk("R7 rise mask read", d, 32'h20);
    rd(ra(0, O_FS), d); chk("R7 fall mask empty", d, 32'h0);
    wr(ra(0, O_FS), 32'h20);
    rd(ra(0, O_FC), d); chk("R7 fall mask read", d, 32'h20);
    pin_in[5] = 1'b1; settle();
    rd(ra(0, O_ST), d); chk("R7 both: rise", d, 32'h20);
    wr(ra(0, O_ST), 32'h20);
    pin_in[5] = 1'b0; settle();
    rd(ra(0, O_ST), d); chk("R7 both: fall", d, 32'h20);
    wr(ra(0, O_ST), 32'h20);
    wr(ra(0, O_RC), 32'h20);
    wr(ra(0, O_FC), 32'h20);
    pin_in[5] = 1'b1; settle();
    rd(ra(0, O_ST), d); chk("R7 disabled by clear ports", d, 32'h0);
  endtask

  task automatic t_groups();
    logic [31:0] d;
    wr(ra(0, O_RS), 32'h0001_0000);
    pin_in[16] = 1'b1; settle();
    chk("R11 pin16 -> line1", 32'(irq), 32'h002);
    wr(ra(0, O_ST), 32'h0001_0000);
    wr(ra(4, O_RS), 32'h0000_8000);
    pin_in[143] = 1'b1; settle();
    chk("R11 pin143 -> line8", 32'(irq), 32'h100);
    wr(8'h08, 32'h0FF);
    chk("R11 line8 gated", 32'(irq), 32'h000);
    wr(8'h08, 32'h1FF);
    chk("R11 line8 reopened", 32'(irq), 32'h100);
    wr(ra(4, O_ST), 32'h0000_8000);
    rd(ra(4, O_ST), d); chk("R11 set4 cleared", d, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(ra(2, O_RS), 32'h3);
    pin_in[65:64] = 2'b11; settle();
    rd(ra(2, O_ST), d); chk("R9 two set", d, 32'h3);
    chk("R11 pins64/65 -> line4", 32'(irq), 32'h010);
    wr(ra(2, O_ST), 32'h1);
    rd(ra(2, O_ST), d); chk("R9 partial clear", d, 32'h2);
    wr(ra(2, O_ST), 32'h0);
    rd(ra(2, O_ST), d); chk("R9 zero write", d, 32'h2);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    pin_in[64] = 1'b0; settle();
    @(negedge clk);
    pin_in[64] = 1'b1;
    @(negedge clk);
    wr(ra(2, O_ST), 32'h1);
    rd(ra(2, O_ST), d); chk("R10 edge beats clear", d, 32'h3);
    wr(ra(2, O_ST), 32'h3);
    rd(ra(2, O_ST), d); chk("R10 later clear works", d, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_dir();
    t_data();
    t_sync();
    t_edges();
    t_groups();
    t_w1c();
    t_collide();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nvec++;
    nerr++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    finish_run();
  end

endmodule